// File: doc/BRIEF.md
# Multicast Event and Data Channel Buffer

This block carries one signal from a single sender to several receivers. The signal is an event paired with a data value. Each receiver has its own one-place buffer: a presence bit and a data word. The sender can stage a data value. It then emits the event. The emission loads the staged value and sets the presence bit in every receiver's buffer on the same clock edge.

A receiver starts a transition by pulsing its take request. On that edge the block copies the presence bit and the buffered word into that receiver's capture register as one snapshot, and it clears the presence bit. Because the event and its value always move together, a captured value can never belong to a different event.

Emissions never wait. When the sender emits before a receiver has consumed the previous event, the new event replaces the old one, and the block raises a one-cycle overwrite pulse for that receiver.

Top module: `evt_chan_buf`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all presence bits, capture-valid bits, captured data words and overwrite pulses read zero.
- R2: An emission sets the presence bit of every receiver on the next edge, and loads the emitted value into every receiver's buffer.
- R3: The emitted value is the most recently staged word. A write and an emission in the same cycle use the word written in that cycle.
- R4: A take on a receiver whose event is present does three things one cycle later: the capture-valid bit reads 1, the captured data equals the buffered value, and the presence bit reads 0 (unless R7 applies).
- R5: A take on a receiver with no event present makes the capture-valid bit read 0, and leaves that receiver's captured data unchanged.
- R6: An emission that reaches a receiver whose presence bit is set, and which has no take in the same cycle, raises that receiver's overwrite output for exactly the following cycle. The buffer then holds the new value. In every other cycle the overwrite output is 0.
- R7: When a take and an emission hit the same receiver in one cycle, that receiver captures the old buffered event and value. Its presence bit stays set, now with the new value, and no overwrite is flagged.
- R8: Receivers are independent. A take on one receiver leaves the presence bit, the buffer and the captured registers of every other receiver unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| snd_wr | input | 1 | Stage `snd_data` as the value for the next emission |
| snd_data | input | DW | Data word from the sender |
| snd_emit | input | 1 | Emit the event to all receivers |
| rx_take | input | N_RX | Per-receiver capture-and-consume request |
| rx_present | output | N_RX | Per-receiver event presence bit |
| rx_cap_valid | output | N_RX | Captured presence from the latest take |
| rx_cap_data | output | N_RX*DW | Captured data words; receiver i occupies bits [i*DW +: DW] |
| rx_ovw | output | N_RX | One-cycle overwrite pulse per receiver |

## Verification
The assertions place no limit on the inputs. Any mix of staging, emission and take is legal in any cycle. That includes a take on an empty buffer, and a take in the same cycle as an emission. For this reason the random stimulus draws every input independently and often overlaps emissions with takes. This overlap is what exercises the overwrite and same-cycle rules. Directed sequences are added for the cases that random draws seldom line up: staging without emission, back-to-back emissions, and a take on one receiver only.

// File: rtl/evt_chan_buf.sv
module evt_chan_buf #(
  parameter int N_RX = 4,
  parameter int DW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snd_wr,
  input  logic [DW-1:0]     snd_data,
  input  logic              snd_emit,
  input  logic [N_RX-1:0]   rx_take,
  output logic [N_RX-1:0]   rx_present,
  output logic [N_RX-1:0]   rx_cap_valid,
  output logic [N_RX*DW-1:0] rx_cap_data,
  output logic [N_RX-1:0]   rx_ovw
);

  logic [DW-1:0] stage_q;
  logic [DW-1:0] emit_val;

  assign emit_val = snd_wr ? snd_data : stage_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      stage_q <= '0;
    else if (snd_wr) stage_q <= snd_data;

  for (genvar i = 0; i < N_RX; i++) begin : g_rx
    logic          pres_q, cval_q, ovw_q;
    logic [DW-1:0] buf_q, cdat_q;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        pres_q <= 1'b0;
        buf_q  <= '0;
        cval_q <= 1'b0;
        cdat_q <= '0;
        ovw_q  <= 1'b0;
      end else begin
        ovw_q <= snd_emit && pres_q && !rx_take[i];
        if (rx_take[i]) begin
          cval_q <= pres_q;
          if (pres_q) cdat_q <= buf_q;
        end
        if (snd_emit) begin
          pres_q <= 1'b1;
          buf_q  <= emit_val;
        end else if (rx_take[i]) begin
          pres_q <= 1'b0;
        end
      end

    assign rx_present[i]             = pres_q;
    assign rx_cap_valid[i]           = cval_q;
    assign rx_cap_data[i*DW +: DW]   = cdat_q;
    assign rx_ovw[i]                 = ovw_q;
  end

endmodule

// File: rtl/evt_chan_buf_chk.sv
module evt_chan_buf_chk #(
  parameter int N_RX = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            snd_emit,
  input logic [N_RX-1:0] rx_take,
  input logic [N_RX-1:0] rx_present,
  input logic [N_RX-1:0] rx_cap_valid,
  input logic [N_RX-1:0] rx_ovw
);

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (rx_present == '0 && rx_cap_valid == '0 && rx_ovw == '0));

  a_r2_emit_sets_all: assert property (@(posedge clk) disable iff (!rst_n)
    snd_emit |=> (&rx_present));

  a_r4_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!snd_emit && |rx_take) |=> ((rx_present & $past(rx_take)) == '0));

  a_r5_empty_take_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    |(rx_take & ~rx_present) |=> ((rx_cap_valid & $past(rx_take & ~rx_present)) == '0));

  a_r6_ovw_needs_emit: assert property (@(posedge clk) disable iff (!rst_n)
    |rx_ovw |-> $past(snd_emit));

  a_r7_take_with_emit_no_ovw: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_emit && |rx_take) |=> ((rx_ovw & $past(rx_take)) == '0));

  a_r8_no_emit_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !snd_emit |=> ((rx_present & ~$past(rx_present)) == '0));

endmodule

bind evt_chan_buf evt_chan_buf_chk #(.N_RX(N_RX)) u_chk (
  .clk(clk), .rst_n(rst_n), .snd_emit(snd_emit), .rx_take(rx_take),
  .rx_present(rx_present), .rx_cap_valid(rx_cap_valid), .rx_ovw(rx_ovw)
);

// File: tb/evt_chan_buf_tb.sv
module evt_chan_buf_tb;
  localparam int N_RX = 4;
  localparam int DW   = 8;
  localparam time CLK_PERIOD = 10ns;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              snd_wr = 1'b0;
  logic [DW-1:0]     snd_data = '0;
  logic              snd_emit = 1'b0;
  logic [N_RX-1:0]   rx_take = '0;
  logic [N_RX-1:0]   rx_present, rx_cap_valid, rx_ovw;
  logic [N_RX*DW-1:0] rx_cap_data;

  evt_chan_buf #(.N_RX(N_RX), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .snd_wr(snd_wr), .snd_data(snd_data),
    .snd_emit(snd_emit), .rx_take(rx_take), .rx_present(rx_present),
    .rx_cap_valid(rx_cap_valid), .rx_cap_data(rx_cap_data), .rx_ovw(rx_ovw));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [DW-1:0] m_stage;
  logic [DW-1:0] m_buf  [N_RX];
  logic [DW-1:0] m_cdat [N_RX];
  logic          m_pres [N_RX];
  logic          m_cval [N_RX];
  logic          m_ovw  [N_RX];

  function automatic logic [DW-1:0] emitted(logic wr, logic [DW-1:0] d, logic [DW-1:0] st);
    return wr ? d : st;
  endfunction

  task automatic model_reset();
    m_stage = '0;
    for (int i = 0; i < N_RX; i++) begin
      m_buf[i] = '0; m_cdat[i] = '0; m_pres[i] = 0; m_cval[i] = 0; m_ovw[i] = 0;
    end
  endtask

  task automatic model_step(logic wr, logic [DW-1:0] d, logic em, logic [N_RX-1:0] tk);
    logic [DW-1:0] v;
    v = emitted(wr, d, m_stage);
    for (int i = 0; i < N_RX; i++) begin
      m_ovw[i] = em && m_pres[i] && !tk[i];
      if (tk[i]) begin
        m_cval[i] = m_pres[i];
        if (m_pres[i]) m_cdat[i] = m_buf[i];
      end
      if (em) begin m_pres[i] = 1; m_buf[i] = v; end
      else if (tk[i]) m_pres[i] = 0;
    end
    if (wr) m_stage = d;
  endtask

  task automatic check(string tag);
    for (int i = 0; i < N_RX; i++) begin
      n_chk++;
      if (rx_present[i] !== m_pres[i] || rx_cap_valid[i] !== m_cval[i] ||
          rx_ovw[i] !== m_ovw[i] || rx_cap_data[i*DW +: DW] !== m_cdat[i]) begin
        n_bad++;
        $display("FAIL %s rx%0d: got pres=%b cval=%b ovw=%b cdat=%h, expected pres=%b cval=%b ovw=%b cdat=%h",
                 tag, i, rx_present[i], rx_cap_valid[i], rx_ovw[i], rx_cap_data[i*DW +: DW],
                 m_pres[i], m_cval[i], m_ovw[i], m_cdat[i]);
      end
    end
  endtask

  task automatic cyc(logic wr, logic [DW-1:0] d, logic em, logic [N_RX-1:0] tk, string tag);
    snd_wr = wr; snd_data = d; snd_emit = em; rx_take = tk;
    model_step(wr, d, em, tk);
    @(negedge clk);
    snd_wr = 0; snd_emit = 0; rx_take = '0;
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    model_reset();
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    // R2 multicast, R3 staged value then emit later
    cyc(1, 8'hA5, 0, '0, "R3");
    cyc(0, 8'h00, 1, '0, "R2");
    cyc(0, 8'h00, 0, 4'b1111, "R4");
    // R3 same-cycle write and emit
    cyc(1, 8'h3C, 1, '0, "R3");
    // R6 back-to-back emit with presence set
    cyc(1, 8'h77, 1, '0, "R6");
    cyc(0, 8'h00, 0, '0, "R6");
    // R8 take one receiver only
    cyc(0, 8'h00, 0, 4'b0100, "R8");
    // R5 take on empty receiver keeps captured data
    cyc(0, 8'h00, 0, 4'b0100, "R5");
    // R7 take and emit together
    cyc(1, 8'h19, 1, 4'b0011, "R7");
    cyc(0, 8'h00, 0, 4'b0011, "R4");

    for (int k = 0; k < 3000; k++) begin
      logic [N_RX-1:0] tk;
      tk = '0;
      for (int i = 0; i < N_RX; i++) tk[i] = ($urandom % 3) == 0;
      cyc(($urandom % 2) == 0, DW'($urandom), ($urandom % 3) == 0, tk, "R8");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule